// File: doc/BRIEF.md
# EEPROM Page-Write Sequencer

This block is a host-side controller for a byte-wide parallel EEPROM. A client hands it a start address and a byte count from 1 to 32, then streams the bytes over a valid/ready interface. The sequencer holds the whole page in a local buffer. It then issues one write strobe per byte with fixed cycle spacing. After the last strobe it watches for the end of the internal programming cycle. The watching method is set per request by a mode input: it can poll the data bit, poll the toggle bit, or wait on the ready/busy pin.

A single-byte read is also offered. It lowers chip enable and output enable, waits a programmable access time, and returns the sampled byte. All analog bus timing is expressed as cycle counts through parameters. A request the device cannot take as one page is refused before any bus activity. A programming cycle that never finishes ends with a timeout flag.

Top module: `eeprom_page_writer`

## Requirements
- R1: A write request with a length of 0, a length above 32, or an address offset within the 32-byte page plus length above 32 raises `err_fmt` for one cycle. It starts no bus cycle, accepts no stream byte and leaves the block idle.
- R2: After an accepted write request, `in_ready` is high until exactly `req_len` bytes have been taken. No write strobe begins before the last byte arrives, however slowly the bytes come.
- R3: Every write strobe holds `mem_we_n` low for at least `WE_LOW_CYC` cycles. Throughout the strobe `mem_ce_n` is low and `mem_oe_n` is high.
- R4: Between strobes `mem_we_n` stays high for at least `WE_HIGH_CYC` cycles. The gap is a fixed count, so a page is never broken up by the device's byte-load timeout.
- R5: Byte k of the stream is written to address `req_addr + k`, in stream order. Addresses outside the request are untouched.
- R6: Mode 0 (data polling) reads the last written address. The write counts as complete when data bit 7 equals bit 7 of the last byte written.
- R7: Mode 1 (toggle polling) repeats reads. The write counts as complete when two reads in a row return the same bit 6.
- R8: Modes 2 and 3 (ready pin) need no reads. The write counts as complete when the synchronised `mem_rdy` is seen high at the end of a wait gap after the last strobe.
- R9: If completion is not seen within `TIMEOUT_CYC` cycles after the last strobe, `err_timeout` pulses, `done` does not, and the block returns to idle with the bus released.
- R10: A read request drives `mem_ce_n` and `mem_oe_n` low with `mem_we_n` high for `ACCESS_CYC` cycles. It then pulses `rd_valid`, with `rd_data` holding the byte sampled at `req_addr`.
- R11: `mem_dq_oe` is high only around and during a write strobe. It is never high while `mem_oe_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| det_mode | input | 2 | Completion method: 0 data poll, 1 toggle, 2/3 ready pin |
| wr_req | input | 1 | Start a page write (one cycle, while idle) |
| rd_req | input | 1 | Start a byte read (one cycle, while idle) |
| req_addr | input | 11 | Start address of the write, or read address |
| req_len | input | 6 | Number of bytes in the write |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Sequencer takes stream bytes |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: write complete |
| err_fmt | output | 1 | One-cycle pulse: request refused |
| err_timeout | output | 1 | One-cycle pulse: completion not seen in time |
| rd_valid | output | 1 | One-cycle pulse: read data valid |
| rd_data | output | 8 | Read result |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | 11 | Memory address |
| mem_dq_o | output | 8 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_o` |
| mem_dq_i | input | 8 | Data from the memory |
| mem_rdy | input | 1 | Ready/busy pin, high when ready |

## Verification
The hardest situation to reach is the page-load window. A memory that starts programming as soon as the byte stream stalls would silently split a page. The bench's memory model therefore starts programming after a short idle count following the last strobe, or at the first read. It flags any strobe that lands after programming has begun. A directed test then holds the last stream byte back for many cycles, to show that no strobe starts early. The model also drives a complemented bit 7, a toggling bit 6 and a low ready pin while it is busy. It can be frozen busy, which lets the timeout path be driven from the ports.

// File: rtl/eepw_pkg.sv
// Package: shared types and helpers of the EEPROM page-write sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package eepw_pkg;

    // Completion detection method; 2'b11 behaves like the ready pin.
    typedef enum logic [1:0] {
        DET_POLL   = 2'd0,
        DET_TOGGLE = 2'd1,
        DET_RDY    = 2'd2,
        DET_RDY_B  = 2'd3
    } det_mode_e;

    // Sequencer states.
    typedef enum logic [3:0] {
        S_IDLE = 4'd0,
        S_FILL = 4'd1,
        S_WSET = 4'd2,
        S_WLOW = 4'd3,
        S_WHLD = 4'd4,
        S_WGAP = 4'd5,
        S_PGAP = 4'd6,
        S_PACC = 4'd7,
        S_RACC = 4'd8
    } seq_state_e;

    function automatic int unsigned eepw_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/eepw_countdown.sv
// Module: down-counter used as a phase or timeout timer.
// Loading N makes zero assert N cycles later. The count holds at zero.
// Assumes: load has priority; value fits in W bits.
module eepw_countdown #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] value,
    output logic         zero
);
    logic [W-1:0] cnt;

    // Load, or count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= value;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/eepw_page_buf.sv
// Module: page staging buffer. Synchronous write, combinational read.
// Assumes: the sequencer writes an index only before strobing it.
module eepw_page_buf #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Store an incoming stream byte.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/eepw_done_detect.sv
// Module: end-of-programming detector.
// It gives a combinational finish verdict for the current sample: a poll
// read, or a wait gap in ready-pin mode. It keeps the previous toggle bit
// and synchronises the ready pin.
// Assumes: clr is held while idle; smp marks a completed read.
module eepw_done_detect
    import eepw_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  det_mode_e         mode,
    input  logic              smp,
    input  logic [DATA_W-1:0] dq,
    input  logic              exp_msb,
    input  logic              rdy_async,
    output logic              fin
);
    localparam int POLL_BIT = DATA_W - 1;
    localparam int TOG_BIT  = DATA_W - 2;

    logic have_prev, prev_tog;
    logic rdy_m, rdy_s;

    // Two-flop synchroniser for the ready/busy pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_m <= 1'b0;
            rdy_s <= 1'b0;
        end else begin
            rdy_m <= rdy_async;
            rdy_s <= rdy_m;
        end
    end

    // Remember the toggle bit of the previous poll read.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            have_prev <= 1'b0;
            prev_tog  <= 1'b0;
        end else if (smp) begin
            have_prev <= 1'b1;
            prev_tog  <= dq[TOG_BIT];
        end
    end

    // Verdict for the present sample under the selected method.
    always_comb begin
        unique case (mode)
            DET_POLL:   fin = (dq[POLL_BIT] == exp_msb);
            DET_TOGGLE: fin = have_prev && (dq[TOG_BIT] == prev_tog);
            default:    fin = rdy_s;
        endcase
    end
endmodule

// File: rtl/eeprom_page_writer.sv
// Module: host-side EEPROM page-write sequencer (top).
// It buffers a 1..32 byte page from a valid/ready stream and strobes the
// bytes with cycle-counted setup/low/hold/gap phases. It then detects
// completion by data poll, toggle poll or ready pin, with a timeout. It
// also performs single-byte reads.
// Assumes: requests arrive only while busy is low; the data bus is split
// into out/enable/in by the pad ring; every phase count is at least 1.
module eeprom_page_writer
    import eepw_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int DATA_W      = 8,
    parameter int PAGE_BYTES  = 32,
    parameter int SETUP_CYC   = 2,
    parameter int WE_LOW_CYC  = 20,
    parameter int HOLD_CYC    = 2,
    parameter int WE_HIGH_CYC = 40,
    parameter int ACCESS_CYC  = 30,
    parameter int TIMEOUT_CYC = 2000000,
    localparam int OFS_W = $clog2(PAGE_BYTES),
    localparam int LEN_W = OFS_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        det_mode,
    input  logic              wr_req,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              busy,
    output logic              done,
    output logic              err_fmt,
    output logic              err_timeout,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i,
    input  logic              mem_rdy
);
    localparam int PH_MAX = eepw_max(eepw_max(SETUP_CYC, WE_LOW_CYC),
                                     eepw_max(eepw_max(HOLD_CYC, WE_HIGH_CYC), ACCESS_CYC));
    localparam int PH_W = $clog2(PH_MAX + 1);
    localparam int TO_W = $clog2(TIMEOUT_CYC + 1);

    seq_state_e        state, state_n;
    det_mode_e         mode_q;
    logic [ADDR_W-1:0] base;
    logic [OFS_W-1:0]  len_m1, idx;
    logic              last7;
    logic              ph_load, ph_zero, to_load, to_zero;
    logic [PH_W-1:0]   ph_val;
    logic              smp, fin, accept, last_idx, bad;
    logic              set_done, set_to, set_rd;
    logic [LEN_W:0]    span;

    assign accept   = (state == S_FILL) && in_valid;
    assign last_idx = (idx == len_m1);
    assign span     = {1'b0, {(LEN_W - OFS_W){1'b0}}, req_addr[OFS_W-1:0]} + {1'b0, req_len};
    assign bad      = (req_len == '0) || (req_len > LEN_W'(PAGE_BYTES))
                   || (span > (LEN_W + 1)'(PAGE_BYTES));

    eepw_countdown #(.W(PH_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .load(ph_load), .value(ph_val), .zero(ph_zero));

    eepw_countdown #(.W(TO_W)) u_tmo (
        .clk(clk), .rst_n(rst_n), .load(to_load),
        .value(TO_W'(TIMEOUT_CYC - 1)), .zero(to_zero));

    eepw_page_buf #(.DEPTH(PAGE_BYTES), .DATA_W(DATA_W)) u_buf (
        .clk(clk), .wr_en(accept), .wr_idx(idx), .wr_data(in_data),
        .rd_idx(idx), .rd_data(mem_dq_o));

    eepw_done_detect #(.DATA_W(DATA_W)) u_det (
        .clk(clk), .rst_n(rst_n), .clr(state == S_IDLE), .mode(mode_q),
        .smp(smp), .dq(mem_dq_i), .exp_msb(last7), .rdy_async(mem_rdy), .fin(fin));

    // Next state, phase timer loads and completion outcomes.
    always_comb begin
        state_n  = state;
        ph_load  = 1'b0;
        ph_val   = '0;
        to_load  = 1'b0;
        smp      = 1'b0;
        set_done = 1'b0;
        set_to   = 1'b0;
        set_rd   = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (wr_req && !bad) begin
                    state_n = S_FILL;
                end else if (rd_req && !wr_req) begin
                    state_n = S_RACC;
                    ph_load = 1'b1;
                    ph_val  = PH_W'(ACCESS_CYC - 1);
                end
            end
            S_FILL: if (accept && last_idx) begin
                state_n = S_WSET;
                ph_load = 1'b1;
                ph_val  = PH_W'(SETUP_CYC - 1);
            end
            S_WSET: if (ph_zero) begin
                state_n = S_WLOW;
                ph_load = 1'b1;
                ph_val  = PH_W'(WE_LOW_CYC - 1);
            end
            S_WLOW: if (ph_zero) begin
                state_n = S_WHLD;
                ph_load = 1'b1;
                ph_val  = PH_W'(HOLD_CYC - 1);
            end
            S_WHLD: if (ph_zero) begin
                state_n = last_idx ? S_PGAP : S_WGAP;
                to_load = last_idx;
                ph_load = 1'b1;
                ph_val  = PH_W'(WE_HIGH_CYC - 1);
            end
            S_WGAP: if (ph_zero) begin
                state_n = S_WSET;
                ph_load = 1'b1;
                ph_val  = PH_W'(SETUP_CYC - 1);
            end
            S_PGAP: begin
                if (to_zero) begin
                    state_n = S_IDLE;
                    set_to  = 1'b1;
                end else if (ph_zero) begin
                    ph_load = 1'b1;
                    if (mode_q == DET_RDY || mode_q == DET_RDY_B) begin
                        ph_val = PH_W'(WE_HIGH_CYC - 1);
                        if (fin) begin
                            state_n  = S_IDLE;
                            set_done = 1'b1;
                        end
                    end else begin
                        state_n = S_PACC;
                        ph_val  = PH_W'(ACCESS_CYC - 1);
                    end
                end
            end
            S_PACC: begin
                if (to_zero) begin
                    state_n = S_IDLE;
                    set_to  = 1'b1;
                end else if (ph_zero) begin
                    smp = 1'b1;
                    if (fin) begin
                        state_n  = S_IDLE;
                        set_done = 1'b1;
                    end else begin
                        state_n = S_PGAP;
                        ph_load = 1'b1;
                        ph_val  = PH_W'(WE_HIGH_CYC - 1);
                    end
                end
            end
            S_RACC: if (ph_zero) begin
                state_n = S_IDLE;
                set_rd  = 1'b1;
            end
            default: state_n = S_IDLE;
        endcase
    end

    // State, request capture, byte index and result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= S_IDLE;
            mode_q      <= DET_POLL;
            base        <= '0;
            len_m1      <= '0;
            idx         <= '0;
            last7       <= 1'b0;
            done        <= 1'b0;
            err_fmt     <= 1'b0;
            err_timeout <= 1'b0;
            rd_valid    <= 1'b0;
            rd_data     <= '0;
        end else begin
            state       <= state_n;
            done        <= set_done;
            err_timeout <= set_to;
            rd_valid    <= set_rd;
            err_fmt     <= (state == S_IDLE) && wr_req && bad;
            if (state == S_IDLE && (wr_req || rd_req)) begin
                base   <= req_addr;
                len_m1 <= OFS_W'(req_len - 1'b1);
                mode_q <= det_mode_e'(det_mode);
                idx    <= '0;
            end
            if (accept) begin
                last7 <= in_data[DATA_W-1];
                idx   <= last_idx ? '0 : idx + 1'b1;
            end
            if (state == S_WHLD && ph_zero && !last_idx) idx <= idx + 1'b1;
            if (set_rd) rd_data <= mem_dq_i;
        end
    end

    // Bus pin decode from the state.
    always_comb begin
        mem_ce_n  = !(state inside {S_WSET, S_WLOW, S_WHLD, S_PACC, S_RACC});
        mem_oe_n  = !(state inside {S_PACC, S_RACC});
        mem_we_n  = (state != S_WLOW);
        mem_dq_oe = (state inside {S_WSET, S_WLOW, S_WHLD});
        if (state == S_PACC)      mem_addr = base + ADDR_W'(len_m1);
        else if (state == S_RACC) mem_addr = base;
        else                      mem_addr = base + ADDR_W'(idx);
    end

    assign busy     = (state != S_IDLE);
    assign in_ready = (state == S_FILL);

    // ---------------- assertions ----------------
    localparam int RUN_W = $clog2(eepw_max(WE_LOW_CYC, WE_HIGH_CYC) + 2);
    logic [RUN_W-1:0] lo_run, hi_run;

    // Saturating run lengths of the write-enable low and high levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_run <= '0;
            hi_run <= RUN_W'(WE_HIGH_CYC);
        end else if (!mem_we_n) begin
            hi_run <= '0;
            if (lo_run < RUN_W'(WE_LOW_CYC)) lo_run <= lo_run + 1'b1;
        end else begin
            lo_run <= '0;
            if (hi_run < RUN_W'(WE_HIGH_CYC)) hi_run <= hi_run + 1'b1;
        end
    end

    a_r3_we_low_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> lo_run >= RUN_W'(WE_LOW_CYC));
    a_r4_we_high_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> hi_run >= RUN_W'(WE_HIGH_CYC));
    a_r3_strobe_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n));
    a_r11_dq_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe);
    a_r11_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe);
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err_timeout));
    a_r1_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err_fmt |-> (mem_ce_n && !in_ready));
endmodule

// File: tb/eeprom_page_writer_tb.sv
`timescale 1ns/1ps
module eeprom_page_writer_tb;
    localparam int T_SET = 1, T_LOW = 4, T_HOLD = 1, T_HIGH = 8, T_ACC = 3, T_TO = 3000;
    localparam int LOADWIN = 40, PROG = 400;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] det_mode = 2'd0;
    logic wr_req = 1'b0, rd_req = 1'b0, in_valid = 1'b0;
    logic [10:0] req_addr = '0;
    logic [5:0]  req_len = '0;
    logic [7:0]  in_data = '0;
    logic in_ready, busy, done, err_fmt, err_timeout, rd_valid;
    logic [7:0] rd_data, mem_dq_o, mem_dq_i;
    logic mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, mem_rdy;
    logic [10:0] mem_addr;

    always #2.5 clk = ~clk;

    eeprom_page_writer #(.SETUP_CYC(T_SET), .WE_LOW_CYC(T_LOW), .HOLD_CYC(T_HOLD),
        .WE_HIGH_CYC(T_HIGH), .ACCESS_CYC(T_ACC), .TIMEOUT_CYC(T_TO)) u_dut (
        .clk(clk), .rst_n(rst_n), .det_mode(det_mode), .wr_req(wr_req), .rd_req(rd_req),
        .req_addr(req_addr), .req_len(req_len), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .busy(busy), .done(done), .err_fmt(err_fmt),
        .err_timeout(err_timeout), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i), .mem_rdy(mem_rdy));

    int n_run = 0, n_fail = 0, cyc = 0;
    bit finished = 0;

    // ---------------- memory model ----------------
    logic [7:0]  arr [2048];
    logic [10:0] pg_a [32];
    logic [7:0]  pg_d [32];
    int pcnt = 0, idle = 0, prog = 0, strobes = 0;
    int lo_run = 0, hi_run = 1000, viol_w = 0, viol_dq = 0, early = 0;
    bit loading = 0, mbusy = 0, stuck = 0, tog = 0, m_last7 = 0;
    logic prev_we = 1'b1, prev_oe = 1'b1;

    initial for (int i = 0; i < 2048; i++) arr[i] = 8'hFF;

    always @(negedge clk) begin
        if (!mem_we_n) begin
            lo_run++;
            if (!mem_dq_oe) viol_dq++;
        end else hi_run++;
        if (!mem_oe_n && mem_dq_oe) viol_dq++;
        if (prev_we && !mem_we_n) begin
            if (hi_run < T_HIGH) viol_w++;
            lo_run = 1;
        end
        if (!prev_we && mem_we_n) begin
            if (lo_run < T_LOW) viol_w++;
            hi_run = 1;
            if (mbusy) early++;
            else if (pcnt < 32) begin
                pg_a[pcnt] = mem_addr;
                pg_d[pcnt] = mem_dq_o;
                pcnt++;
            end
            m_last7 = mem_dq_o[7];
            strobes++;
            loading = 1;
            idle = 0;
        end
        if (loading) begin
            idle++;
            if (idle >= LOADWIN || (prev_oe && !mem_oe_n && !mem_ce_n)) begin
                loading = 0; mbusy = 1; prog = 0; tog = 0;
            end
        end else if (mbusy) begin
            if (!prev_oe && mem_oe_n) tog = ~tog;
            prog++;
            if (prog >= PROG && !stuck) begin
                for (int k = 0; k < pcnt; k++) arr[pg_a[k]] = pg_d[k];
                pcnt = 0;
                mbusy = 0;
            end
        end
        prev_we = mem_we_n;
        prev_oe = mem_oe_n;
    end

    always_comb begin
        mem_rdy = !(mbusy || loading);
        if (mbusy)                      mem_dq_i = {~m_last7, tog, 6'b0};
        else if (!mem_ce_n && !mem_oe_n) mem_dq_i = arr[mem_addr];
        else                             mem_dq_i = 8'hFF;
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input logic [10:0] a, input logic [7:0] s);
        return a[7:0] * 8'd13 ^ s;
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            finish_run();
        end
    end

    // Issue a write request and stream len bytes, optionally stalling before the last.
    task automatic do_write(input logic [10:0] a, input int len, input logic [1:0] m,
                            input logic [7:0] s, input int stall, output int st_before_last);
        @(negedge clk);
        wr_req = 1; req_addr = a; req_len = 6'(len); det_mode = m;
        @(negedge clk);
        wr_req = 0;
        st_before_last = strobes;
        for (int i = 0; i < len; ) begin
            if (i == len - 1 && stall > 0) begin
                in_valid = 0;
                repeat (stall) @(negedge clk);
                st_before_last = strobes;
                stall = 0;
            end
            in_valid = 1; in_data = pat(a + 11'(i), s);
            begin
                bit acc = in_ready;
                @(negedge clk);
                if (acc) i++;
            end
        end
        in_valid = 0;
    endtask

    // Wait for done or timeout; report which one.
    task automatic wait_end(output bit got_done, output bit got_to);
        got_done = 0; got_to = 0;
        for (int i = 0; i < 8000 && !got_done && !got_to; i++) begin
            @(negedge clk);
            if (done) got_done = 1;
            if (err_timeout) got_to = 1;
        end
    endtask

    task automatic read_byte(input logic [10:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_req = 1; req_addr = a;
        @(negedge clk);
        rd_req = 0;
        d = 8'hxx;
        for (int i = 0; i < 50; i++) begin
            if (rd_valid) begin d = rd_data; break; end
            @(negedge clk);
        end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(mem_ce_n && mem_oe_n && mem_we_n, "R11 reset bus idle", {mem_ce_n, mem_oe_n, mem_we_n}, 7);
        chk(!mem_dq_oe, "R11 reset dq released", mem_dq_oe, 0);
        chk(!busy && !in_ready, "R2 reset idle", {busy, in_ready}, 0);
        chk(!done && !err_fmt && !err_timeout && !rd_valid, "R9 reset no pulses",
            {done, err_fmt, err_timeout, rd_valid}, 0);
    endtask

    task automatic t_reject(input logic [10:0] a, input int len, input string tag);
        int s0 = strobes;
        bit seen = 0, rdy_seen = 0, bus = 0;
        @(negedge clk);
        wr_req = 1; req_addr = a; req_len = 6'(len);
        @(negedge clk);
        wr_req = 0;
        for (int i = 0; i < 20; i++) begin
            if (err_fmt) seen = 1;
            if (in_ready) rdy_seen = 1;
            if (!mem_ce_n) bus = 1;
            @(negedge clk);
        end
        chk(seen, {"R1 refused ", tag}, seen, 1);
        chk(!rdy_seen && !bus && !busy && strobes == s0, {"R1 no activity ", tag},
            strobes - s0, 0);
    endtask

    task automatic t_write_poll();
        bit d, t; int sb; logic [7:0] v;
        int s0 = strobes;
        do_write(11'h040, 4, 2'd0, 8'h5A, 0, sb);
        wait_end(d, t);
        chk(d && !t, "R6 poll done", {d, t}, 2);
        chk(!mbusy && !loading, "R6 done only after programming", mbusy, 0);
        chk(strobes - s0 == 4, "R3 one strobe per byte", strobes - s0, 4);
        for (int k = 0; k < 4; k++) begin
            read_byte(11'h040 + 11'(k), v);
            chk(v == pat(11'h040 + 11'(k), 8'h5A), "R5 poll readback", v, pat(11'h040 + 11'(k), 8'h5A));
        end
        read_byte(11'h044, v);
        chk(v == 8'hFF, "R5 neighbour untouched", v, 8'hFF);
    endtask

    task automatic t_write_toggle();
        bit d, t; int sb; logic [7:0] v;
        int s0 = strobes;
        do_write(11'h1E0, 32, 2'd1, 8'hC3, 0, sb);
        wait_end(d, t);
        chk(d && !t, "R7 toggle done", {d, t}, 2);
        chk(!mbusy, "R7 done after toggling stops", mbusy, 0);
        chk(strobes - s0 == 32, "R2 full page accepted", strobes - s0, 32);
        read_byte(11'h1E0, v);
        chk(v == pat(11'h1E0, 8'hC3), "R5 page first", v, pat(11'h1E0, 8'hC3));
        read_byte(11'h1FF, v);
        chk(v == pat(11'h1FF, 8'hC3), "R5 page last", v, pat(11'h1FF, 8'hC3));
    endtask

    task automatic t_write_rdy();
        bit d, t; int sb; logic [7:0] v;
        do_write(11'h105, 5, 2'd2, 8'h11, 0, sb);
        wait_end(d, t);
        chk(d && !t, "R8 ready-pin done", {d, t}, 2);
        chk(!mbusy && !loading, "R8 done after pin high", mbusy, 0);
        read_byte(11'h109, v);
        chk(v == pat(11'h109, 8'h11), "R8 ready-pin readback", v, pat(11'h109, 8'h11));
    endtask

    task automatic t_stall();
        bit d, t; int sb; logic [7:0] v;
        int s0 = strobes;
        do_write(11'h300, 3, 2'd0, 8'h77, 80, sb);
        chk(sb == s0, "R2 no strobe before last byte", sb - s0, 0);
        wait_end(d, t);
        chk(d, "R2 stalled write done", d, 1);
        chk(early == 0, "R4 no strobe after load window", early, 0);
        read_byte(11'h302, v);
        chk(v == pat(11'h302, 8'h77), "R5 stalled readback", v, pat(11'h302, 8'h77));
    endtask

    task automatic t_timeout();
        bit d, t; int sb;
        stuck = 1;
        do_write(11'h500, 1, 2'd0, 8'h0F, 0, sb);
        wait_end(d, t);
        chk(t && !d, "R9 timeout flagged", {d, t}, 1);
        @(negedge clk);
        chk(!busy && mem_ce_n && mem_oe_n && !mem_dq_oe, "R9 back to idle",
            {busy, mem_ce_n, mem_oe_n}, 3);
        stuck = 0;
        repeat (PROG + 20) @(negedge clk);
    endtask

    task automatic t_read();
        logic [7:0] v;
        @(negedge clk);
        rd_req = 1; req_addr = 11'h041;
        @(negedge clk);
        rd_req = 0;
        chk(!mem_ce_n && !mem_oe_n && mem_we_n, "R10 read strobes",
            {mem_ce_n, mem_oe_n, mem_we_n}, 1);
        chk(mem_addr == 11'h041, "R10 read address", mem_addr, 11'h041);
        v = 8'hxx;
        for (int i = 0; i < 20; i++) begin
            if (rd_valid) begin v = rd_data; break; end
            @(negedge clk);
        end
        chk(v == pat(11'h041, 8'h5A), "R10 read data", v, pat(11'h041, 8'h5A));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_reject(11'h010, 0, "len0");
        t_reject(11'h000, 33, "len33");
        t_reject(11'h01E, 4, "cross");
        t_write_poll();
        t_write_toggle();
        t_write_rdy();
        t_stall();
        t_timeout();
        t_read();
        chk(viol_w == 0, "R3 R4 strobe widths", viol_w, 0);
        chk(viol_dq == 0, "R11 data drive window", viol_dq, 0);
        finish_run();
    end
endmodule